// File: doc/BRIEF.md
# DMA Chain Loader

This block is the sequencer of a single DMA channel. It works through a linked list of transfer control blocks (TCBs) held in local memory. Each TCB has four words: a start index, a modifier, a transfer count and a link. The host sees two registers. The control register carries the chaining enable in bit 0. The chain pointer register starts the loader when it is written.

A pointer value packs two things. Bits 18:0 hold the memory address of the TCB's index word, which is the TCB base plus 3; the link word sits at the base itself. Bit 19 asks for a completion interrupt for the TCB that pointer leads to. All other bits are ignored.

Once started, the loader reads the four words downward through a memory read port with one cycle of latency. It then accepts one transfer strobe per cycle from the data mover. Each strobe adds the modifier to the index and takes one from the count. When the count reaches zero, the loader raises the interrupt if one was requested. It then follows the link, or a pointer the host wrote meanwhile. A zero address ends the chain.

States: `ST_IDLE` (no work), `ST_RD_IDX`, `ST_RD_MOD`, `ST_RD_CNT`, `ST_RD_LNK` (one read request each), `ST_LNK_WAIT` (last read returns), `ST_RUN` (transfers accepted), `ST_DONE` (sequence finished).

Transitions:
- Start: `ST_IDLE` to `ST_RD_IDX`.
- Fetch steps: `ST_RD_IDX` to `ST_RD_MOD` to `ST_RD_CNT` to `ST_RD_LNK` to `ST_LNK_WAIT`.
- Loaded: `ST_LNK_WAIT` to `ST_RUN` when the count is nonzero.
- Empty: `ST_LNK_WAIT` to `ST_DONE` when the count is zero.
- Last: `ST_RUN` to `ST_DONE` on the strobe that takes the count from 1 to 0.
- Follow: `ST_DONE` to `ST_RD_IDX`.
- Stop: `ST_DONE` to `ST_IDLE`.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `idle` is 1, and `xfer_ready`, `done_irq` and `mem_rd_en` are 0.
- R2: With chaining enabled, a chain pointer write (`host_sel`=1) with a nonzero address field starts a fetch. The fetch issues four consecutive reads at A, A-1, A-2 and A-3, where A is bits 18:0 of the written value and higher bits are ignored. `xfer_ready` rises 5 cycles after the write edge, with `cur_index` and `cur_count` equal to the words read at A and A-2.
- R3: A chain pointer write while chaining is disabled, or one whose address field is zero, issues no read and leaves `idle` at 1.
- R4: Each cycle with `xfer_ready` and `xfer_strobe` both high adds the modifier (read at A-1) to the index, modulo 2^19, and decrements the count. A strobe while `xfer_ready` is low has no effect.
- R5: When the count reaches 0, `done_irq` pulses for exactly one cycle if bit 19 of the pointer that led to the TCB was set. If that bit was clear, there is no pulse.
- R6: After a sequence ends, a nonzero link address (read at A-3, same packing as a pointer) starts the next fetch. A zero link address returns the block to idle.
- R7: A chain pointer write while the block is not idle is held. At the next link it replaces the fetched link. A held value of 0 ends the chain there.
- R8: A TCB whose count word is 0 finishes without accepting any transfer. It still raises its interrupt when requested and then follows its link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 selects the control register, 1 the chain pointer |
| host_wdata | input | 32 | Host write data |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 19 | Memory read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| xfer_strobe | input | 1 | A transfer was performed this cycle |
| xfer_ready | output | 1 | A sequence is running and accepts transfers |
| cur_index | output | 19 | Current index register |
| cur_count | output | 16 | Current count register |
| done_irq | output | 1 | One-cycle completion interrupt |
| idle | output | 1 | No fetch or sequence in progress |

## Verification
The hardest case to reach is a host pointer write that lands while a sequence is already running. The held value has to override the link that was just fetched from memory. The bench starts a chain whose fetched link points at a valid TCB, waits for `xfer_ready`, and writes a different pointer before the last strobe. It then checks that the next sequence loads the other TCB. The same steps are repeated with a zero pointer, and the bench checks that no further reads follow. A zero-count TCB with an interrupt request is reached as the second link of a chain, so the run → done → fetch → done path is covered.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_IDX,
        ST_RD_MOD,
        ST_RD_CNT,
        ST_RD_LNK,
        ST_LNK_WAIT,
        ST_RUN,
        ST_DONE
    } dcl_state_t;

endpackage

// File: rtl/dcl_host_if.sv
module dcl_host_if #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 19,
    parameter int IRQ_POS = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              take_pend,
    output logic              chain_en,
    output logic              start,
    output logic [ADDR_W:0]   start_ptr,
    output logic              pend_valid,
    output logic [ADDR_W:0]   pend_ptr
);

    logic ptr_wr;
    logic ctl_wr;
    logic unused_wdata;

    assign ptr_wr       = host_wr & host_sel;
    assign ctl_wr       = host_wr & ~host_sel;
    assign start_ptr    = {host_wdata[IRQ_POS], host_wdata[ADDR_W-1:0]};
    assign start        = ptr_wr & ~busy & chain_en & (|start_ptr[ADDR_W-1:0]);
    assign unused_wdata = ^host_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_en <= 1'b0;
        end else if (ctl_wr) begin
            chain_en <= host_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_ptr   <= '0;
        end else begin
            if (take_pend || start) begin
                pend_valid <= 1'b0;
            end
            if (ptr_wr && busy) begin
                pend_valid <= 1'b1;
                pend_ptr   <= start_ptr;
            end
        end
    end

endmodule

// File: rtl/dcl_tcb_regs.sv
module dcl_tcb_regs #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 19,
    parameter int CNT_W   = 16,
    parameter int IRQ_POS = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_idx,
    input  logic              ld_mod,
    input  logic              ld_cnt,
    input  logic              ld_lnk,
    input  logic              step,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] index,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W:0]   link,
    output logic              cnt_zero,
    output logic              cnt_last
);

    logic [ADDR_W-1:0] modifier;
    logic              unused_rd;

    assign cnt_zero  = (count == '0);
    assign cnt_last  = (count == CNT_W'(1));
    assign unused_rd = ^rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index <= '0;
        end else if (ld_idx) begin
            index <= rd_data[ADDR_W-1:0];
        end else if (step) begin
            index <= index + modifier;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            modifier <= '0;
        end else if (ld_mod) begin
            modifier <= rd_data[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld_cnt) begin
            count <= rd_data[CNT_W-1:0];
        end else if (step) begin
            count <= count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link <= '0;
        end else if (ld_lnk) begin
            link <= {rd_data[IRQ_POS], rd_data[ADDR_W-1:0]};
        end
    end

endmodule

// File: rtl/dcl_seq_fsm.sv
module dcl_seq_fsm
    import dcl_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   start_ptr,
    input  logic              chain_en,
    input  logic              pend_valid,
    input  logic [ADDR_W:0]   pend_ptr,
    input  logic [ADDR_W:0]   link,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              xfer_strobe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              ld_idx,
    output logic              ld_mod,
    output logic              ld_cnt,
    output logic              ld_lnk,
    output logic              step,
    output logic              take_pend,
    output logic              done_irq,
    output logic              busy,
    output logic              xfer_ready
);

    dcl_state_t        state, state_nx;
    logic [ADDR_W:0]   fetch_ptr;
    logic [ADDR_W:0]   next_ptr;
    logic              follow;
    logic [ADDR_W-1:0] rd_ofs;

    assign next_ptr = pend_valid ? pend_ptr : link;
    assign follow   = chain_en && (|next_ptr[ADDR_W-1:0]);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_RD_IDX;
            ST_RD_IDX:   state_nx = ST_RD_MOD;
            ST_RD_MOD:   state_nx = ST_RD_CNT;
            ST_RD_CNT:   state_nx = ST_RD_LNK;
            ST_RD_LNK:   state_nx = ST_LNK_WAIT;
            ST_LNK_WAIT: state_nx = cnt_zero ? ST_DONE : ST_RUN;
            ST_RUN:      if (xfer_strobe && cnt_last) state_nx = ST_DONE;
            ST_DONE:     state_nx = follow ? ST_RD_IDX : ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fetch_ptr <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                fetch_ptr <= start_ptr;
            end else if (state == ST_DONE) begin
                fetch_ptr <= next_ptr;
            end
        end
    end

    always_comb begin
        mem_rd_en  = 1'b0;
        rd_ofs     = '0;
        ld_idx     = 1'b0;
        ld_mod     = 1'b0;
        ld_cnt     = 1'b0;
        ld_lnk     = 1'b0;
        step       = 1'b0;
        take_pend  = 1'b0;
        done_irq   = 1'b0;
        busy       = 1'b1;
        xfer_ready = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_RD_IDX: begin
                mem_rd_en = 1'b1;
                rd_ofs    = ADDR_W'(0);
            end
            ST_RD_MOD: begin
                mem_rd_en = 1'b1;
                rd_ofs    = ADDR_W'(1);
                ld_idx    = 1'b1;
            end
            ST_RD_CNT: begin
                mem_rd_en = 1'b1;
                rd_ofs    = ADDR_W'(2);
                ld_mod    = 1'b1;
            end
            ST_RD_LNK: begin
                mem_rd_en = 1'b1;
                rd_ofs    = ADDR_W'(3);
                ld_cnt    = 1'b1;
            end
            ST_LNK_WAIT: ld_lnk = 1'b1;
            ST_RUN: begin
                xfer_ready = 1'b1;
                step       = xfer_strobe;
            end
            ST_DONE: begin
                take_pend = 1'b1;
                done_irq  = fetch_ptr[ADDR_W];
            end
            default: busy = 1'b0;
        endcase
    end

    assign mem_rd_addr = fetch_ptr[ADDR_W-1:0] - rd_ofs;

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 19,
    parameter int CNT_W   = 16,
    parameter int IRQ_POS = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              xfer_strobe,
    output logic              xfer_ready,
    output logic [ADDR_W-1:0] cur_index,
    output logic [CNT_W-1:0]  cur_count,
    output logic              done_irq,
    output logic              idle
);

    localparam int PTR_W = ADDR_W + 1;

    logic             busy, take_pend, chain_en, start, pend_valid;
    logic [PTR_W-1:0] start_ptr, pend_ptr, link;
    logic             ld_idx, ld_mod, ld_cnt, ld_lnk, step;
    logic             cnt_zero, cnt_last;

    dcl_host_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_POS(IRQ_POS)) u_host (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .busy(busy), .take_pend(take_pend),
        .chain_en(chain_en), .start(start), .start_ptr(start_ptr),
        .pend_valid(pend_valid), .pend_ptr(pend_ptr)
    );

    dcl_tcb_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IRQ_POS(IRQ_POS)) u_regs (
        .clk(clk), .rst_n(rst_n), .ld_idx(ld_idx), .ld_mod(ld_mod),
        .ld_cnt(ld_cnt), .ld_lnk(ld_lnk), .step(step), .rd_data(mem_rd_data),
        .index(cur_index), .count(cur_count), .link(link),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last)
    );

    dcl_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
        .chain_en(chain_en), .pend_valid(pend_valid), .pend_ptr(pend_ptr),
        .link(link), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
        .xfer_strobe(xfer_strobe), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .ld_idx(ld_idx), .ld_mod(ld_mod),
        .ld_cnt(ld_cnt), .ld_lnk(ld_lnk), .step(step), .take_pend(take_pend),
        .done_irq(done_irq), .busy(busy), .xfer_ready(xfer_ready)
    );

    assign idle = ~busy;

endmodule

// File: rtl/dcl_chk.sv
module dcl_chk #(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              xfer_strobe,
    input logic              xfer_ready,
    input logic [ADDR_W-1:0] cur_index,
    input logic [CNT_W-1:0]  cur_count,
    input logic              done_irq,
    input logic              idle
);

    // R2
    rd_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) - ADDR_W'(1)));

    // R3
    rd_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !idle);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ready && xfer_strobe) |=> (cur_count == $past(cur_count) - CNT_W'(1)));

    // R4
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ready && !xfer_strobe) |=> $stable(cur_index));

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R5
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (cur_count == '0 && !xfer_ready));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!xfer_ready && !done_irq && !mem_rd_en));

endmodule

bind dma_chain_seq dcl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .xfer_strobe(xfer_strobe), .xfer_ready(xfer_ready), .cur_index(cur_index),
    .cur_count(cur_count), .done_irq(done_irq), .idle(idle)
);

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        mem_rd_en;
    logic [18:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        xfer_strobe = 1'b0;
    logic        xfer_ready;
    logic [18:0] cur_index;
    logic [15:0] cur_count;
    logic        done_irq;
    logic        idle;

    int errors = 0;
    int checks = 0;
    int irq_cnt = 0;
    int rd_n = 0;
    logic [31:0] mem [0:63];
    logic [18:0] rd_log [0:15];

    localparam logic [31:0] IRQB = 32'h0008_0000;

    dma_chain_seq uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .xfer_strobe(xfer_strobe), .xfer_ready(xfer_ready),
        .cur_index(cur_index), .cur_count(cur_count), .done_irq(done_irq), .idle(idle)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr[5:0]];
            rd_log[rd_n % 16] = mem_rd_addr;
            rd_n = rd_n + 1;
        end
    end

    always @(negedge clk) if (done_irq) irq_cnt = irq_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
    endtask

    task automatic strobe();
        @(negedge clk); xfer_strobe = 1'b1;
        @(negedge clk); xfer_strobe = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!xfer_ready && n < 40) begin @(negedge clk); n++; end
        chk(req, {31'd0, xfer_ready}, 32'd1);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (!idle && n < 40) begin @(negedge clk); n++; end
        chk(req, {31'd0, idle}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 idle", {31'd0, idle}, 32'd1);
        chk("R1 ready", {31'd0, xfer_ready}, 32'd0);
        chk("R1 irq", {31'd0, done_irq}, 32'd0);
        chk("R1 rd_en", {31'd0, mem_rd_en}, 32'd0);
    endtask

    task automatic t_ignored();
        int r0;
        host_write(1'b0, 32'd0);
        r0 = rd_n;
        host_write(1'b1, 32'd11);
        repeat (8) @(negedge clk);
        chk("R3 chain off idle", {31'd0, idle}, 32'd1);
        chk("R3 chain off reads", rd_n - r0, 0);
        host_write(1'b0, 32'd1);
        host_write(1'b1, IRQB);
        repeat (8) @(negedge clk);
        chk("R3 zero addr idle", {31'd0, idle}, 32'd1);
        chk("R3 zero addr reads", rd_n - r0, 0);
    endtask

    task automatic t_single();
        int r0, i0;
        r0 = rd_n; i0 = irq_cnt;
        host_write(1'b1, 32'd11 | IRQB | 32'h0200_0000);
        @(negedge clk); xfer_strobe = 1'b1;
        @(negedge clk); xfer_strobe = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 not ready early", {31'd0, xfer_ready}, 32'd0);
        @(negedge clk);
        chk("R2 ready after 5", {31'd0, xfer_ready}, 32'd1);
        chk("R2 read count", rd_n - r0, 4);
        for (int k = 0; k < 4; k++) chk("R2 read addr", {13'd0, rd_log[(r0 + k) % 16]}, 11 - k);
        chk("R2 index load", {13'd0, cur_index}, 32'd100);
        chk("R4 strobe ignored in fetch", {16'd0, cur_count}, 32'd3);
        strobe();
        chk("R4 index step", {13'd0, cur_index}, 32'd104);
        chk("R4 count step", {16'd0, cur_count}, 32'd2);
        repeat (3) @(negedge clk);
        chk("R4 no strobe hold", {13'd0, cur_index}, 32'd104);
        strobe();
        strobe();
        chk("R5 irq pulse", {31'd0, done_irq}, 32'd1);
        chk("R4 final index", {13'd0, cur_index}, 32'd112);
        @(negedge clk);
        chk("R5 pulse ends", {31'd0, done_irq}, 32'd0);
        chk("R6 zero link idle", {31'd0, idle}, 32'd1);
        chk("R5 irq count", irq_cnt - i0, 1);
    endtask

    task automatic t_chain();
        int i0;
        i0 = irq_cnt;
        host_write(1'b1, 32'd19);
        wait_ready("R2 chain start");
        chk("R2 index A", {13'd0, cur_index}, 32'd200);
        strobe();
        chk("R4 wrap modifier", {13'd0, cur_index}, 32'd199);
        strobe();
        chk("R5 no irq when clear", {31'd0, done_irq}, 32'd0);
        wait_idle("R6 chain ends");
        chk("R8 zero count index", {13'd0, cur_index}, 32'd50);
        chk("R8 zero count count", {16'd0, cur_count}, 32'd0);
        chk("R8 zero count irq", irq_cnt - i0, 1);
    endtask

    task automatic t_override();
        int i0;
        i0 = irq_cnt;
        host_write(1'b1, 32'd19);
        wait_ready("R7 start A");
        host_write(1'b1, 32'd35 | IRQB);
        strobe();
        strobe();
        wait_ready("R7 next ready");
        chk("R7 held pointer used", {13'd0, cur_index}, 32'd7);
        chk("R7 held count", {16'd0, cur_count}, 32'd1);
        strobe();
        wait_idle("R7 held chain ends");
        chk("R7 irq from held ptr", irq_cnt - i0, 1);
    endtask

    task automatic t_stop();
        int r0;
        host_write(1'b1, 32'd19);
        wait_ready("R7 start stop");
        r0 = rd_n;
        host_write(1'b1, 32'd0);
        strobe();
        strobe();
        repeat (8) @(negedge clk);
        chk("R7 zero write idle", {31'd0, idle}, 32'd1);
        chk("R7 no further reads", rd_n - r0, 0);
        chk("R7 last index", {13'd0, cur_index}, 32'd198);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[11] = 32'd100; mem[10] = 32'd4;        mem[9]  = 32'd3;  mem[8]  = 32'd0;
        mem[19] = 32'd200; mem[18] = 32'h0007FFFF; mem[17] = 32'd2;  mem[16] = 32'd27 | IRQB;
        mem[27] = 32'd50;  mem[26] = 32'd0;        mem[25] = 32'd0;  mem[24] = 32'd0;
        mem[35] = 32'd7;   mem[34] = 32'd1;        mem[33] = 32'd1;  mem[32] = 32'd0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignored();
        t_single();
        t_chain();
        t_override();
        t_stop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule